// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block safely retunes a clock-multiplying PLL. Software presents a new triple of settings (input pre-divide ratio N, feedback multiplier M, output post-divide ratio P) on a one-cycle write strobe. The block checks the triple against the legal ranges and the allowed VCO frequency window. If the triple is legal and changes N or M, the block runs a hardware sequence. It drops the PLL output to bypass, computes the lock interval with a small iterative divider, and holds the PLL reset for a minimum time. It then waits out the lock interval, counted in reference clock cycles, and enables the PLL output again. A write that changes only P takes a fast path and does not disturb the PLL.

The block runs on the reference clock. The reference frequency is a parameter in kHz, and the reset pulse width is a parameter in nanoseconds that is converted into reference cycles, rounding up. After the block's own reset, it loads the default settings and runs one full sequence before it enables the output. The analog PLL and the downstream dividers lie outside this block. Its outputs are only the control levels and the settings that the PLL should use.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the settings read N=1, M=20, P=1, `busy` is 1 and `pll_en` is 0. One full sequence (R4, R5) then runs with these defaults before `pll_en` first rises.
- R2: A write made while `busy`=0 with N outside 1..32, M outside 4..32 or P outside 1..32 is rejected. The next cycle shows `cfg_err`=1 and all three settings unchanged.
- R3: A write whose VCO frequency REF_KHZ·M/N lies outside 300000..600000 kHz (bounds inclusive) is rejected in the same way as R2. The bench uses the default REF_KHZ=25000, so M must lie in 12N..24N.
- R4: A legal write that changes N or M, made while `busy`=0, shows the new settings with `busy`=1 and `pll_en`=0 in the next cycle. `pll_rst` is later held high for exactly ceil(RST_NS·REF_KHZ/10^6) cycles, which is 25 with the defaults.
- R5: After `pll_rst` falls, `pll_en` stays low for exactly ceil(2000·N/M) cycles and then rises. `busy` falls in the same cycle.
- R6: A legal write made while `busy`=0 with N and M equal to the current values updates P in the next cycle. `pll_rst` stays low, `pll_en` stays high and `busy` stays low.
- R7: A write made while `busy`=1 is ignored, and the running sequence completes with the earlier settings. `overrun` is 1 from the next cycle and stays 1.
- R8: An accepted legal write clears both `cfg_err` and `overrun` in the next cycle.
- R9: `pll_rst` and `pll_en` are never high together, and `pll_rst` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-cycle write strobe for a new settings triple |
| wr_prediv | input | FW | Requested pre-divide ratio N |
| wr_mult | input | FW | Requested multiplier M |
| wr_postdiv | input | FW | Requested post-divide ratio P |
| pll_en | output | 1 | 1 selects the PLL output, 0 selects bypass |
| pll_rst | output | 1 | PLL reset, active high |
| prediv_out | output | FW | Pre-divide ratio applied to the PLL |
| mult_out | output | FW | Multiplier applied to the PLL |
| postdiv_out | output | FW | Post-divide ratio applied to the PLL |
| busy | output | 1 | Sequence running; writes are refused |
| cfg_err | output | 1 | The last write that was not refused had illegal settings |
| overrun | output | 1 | Sticky: a write arrived while busy |

## Verification
The hardest case to reach is a write that lands in the middle of a running sequence. The bench has to see that the write is dropped, that the sequence still times its reset and lock windows from the old settings, and that a later accepted write clears the flag. The bench issues a full retune and then, a few cycles later, strikes with a different triple while `busy` is high. It measures the pulse widths to the exact cycle. Random triples come from a fixed seed, and about half are drawn from the narrow legal band. This keeps full sequences, fast post-divide updates, and both kinds of rejection (range and frequency window) all frequent.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_BYPASS = 3'd1,
      ST_RESET  = 3'd2,
      ST_LOCK   = 3'd3,
      ST_ENABLE = 3'd4
   } seq_state_t;

   // Integer ceiling division used for elaboration-time constants.
   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

endpackage

// File: rtl/pll_cfg_check.sv
module pll_cfg_check #(
   parameter int FW         = 6,
   parameter int NMAX       = 32,
   parameter int MMIN       = 4,
   parameter int MMAX       = 32,
   parameter int PMAX       = 32,
   parameter int REF_KHZ    = 25000,
   parameter int FMIN_KHZ   = 300000,
   parameter int FMAX_KHZ   = 600000,
   parameter bit CHECK_FREQ = 1'b1
) (
   input  logic [FW-1:0] n,
   input  logic [FW-1:0] m,
   input  logic [FW-1:0] p,
   output logic          ok
);
   localparam int PW = 48;
   localparam logic [FW-1:0] ONE_V  = FW'(1);
   localparam logic [FW-1:0] NMAX_V = FW'(NMAX);
   localparam logic [FW-1:0] MMIN_V = FW'(MMIN);
   localparam logic [FW-1:0] MMAX_V = FW'(MMAX);
   localparam logic [FW-1:0] PMAX_V = FW'(PMAX);

   logic range_ok;
   logic freq_ok;

   assign range_ok = (n >= ONE_V) && (n <= NMAX_V) &&
                     (m >= MMIN_V) && (m <= MMAX_V) &&
                     (p >= ONE_V) && (p <= PMAX_V);

   generate
      if (CHECK_FREQ) begin : g_freq
         logic [PW-1:0] vco_scaled;
         logic [PW-1:0] lo_bound;
         logic [PW-1:0] hi_bound;
         assign vco_scaled = PW'(REF_KHZ) * PW'(m);
         assign lo_bound   = PW'(FMIN_KHZ) * PW'(n);
         assign hi_bound   = PW'(FMAX_KHZ) * PW'(n);
         assign freq_ok    = (vco_scaled >= lo_bound) && (vco_scaled <= hi_bound);
      end else begin : g_nofreq
         assign freq_ok = 1'b1;
      end
   endgenerate

   assign ok = range_ok && freq_ok;

endmodule

// File: rtl/pll_lock_div.sv
module pll_lock_div #(
   parameter int NUM_W = 16,
   parameter int DEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             done,
   output logic [NUM_W-1:0] quo
);
   localparam int RW = DEN_W + 1;
   localparam int CW = $clog2(NUM_W + 1);

   logic [RW-1:0]    rem_q;
   logic [NUM_W-1:0] q_q;
   logic [CW-1:0]    left_q;
   logic             done_q;
   logic [RW-1:0]    shifted;
   logic             fits;

   initial begin
      if (NUM_W < 2) $error("pll_lock_div: NUM_W too small");
      if (DEN_W < 1) $error("pll_lock_div: DEN_W too small");
   end

   // One restoring step per cycle: bring down the next numerator bit.
   assign shifted = {rem_q[RW-2:0], q_q[NUM_W-1]};
   assign fits    = shifted >= {1'b0, den};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         q_q    <= '0;
         left_q <= '0;
         done_q <= 1'b0;
      end else if (start) begin
         rem_q  <= '0;
         q_q    <= num;
         left_q <= CW'(NUM_W);
         done_q <= 1'b0;
      end else if (left_q != '0) begin
         rem_q  <= fits ? (shifted - {1'b0, den}) : shifted;
         q_q    <= {q_q[NUM_W-2:0], fits};
         left_q <= left_q - 1'b1;
         done_q <= (left_q == CW'(1));
      end else begin
         done_q <= 1'b0;
      end
   end

   assign done = done_q;
   assign quo  = q_q;

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
   import pll_seq_pkg::*;
#(
   parameter int FW         = 6,
   parameter int NMAX       = 32,
   parameter int MMIN       = 4,
   parameter int MMAX       = 32,
   parameter int PMAX       = 32,
   parameter int N_DEF      = 1,
   parameter int M_DEF      = 20,
   parameter int P_DEF      = 1,
   parameter int REF_KHZ    = 25000,
   parameter int FMIN_KHZ   = 300000,
   parameter int FMAX_KHZ   = 600000,
   parameter int LOCK_K     = 2000,
   parameter int RST_NS     = 1000,
   parameter bit CHECK_FREQ = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [FW-1:0] wr_prediv,
   input  logic [FW-1:0] wr_mult,
   input  logic [FW-1:0] wr_postdiv,
   output logic          pll_en,
   output logic          pll_rst,
   output logic [FW-1:0] prediv_out,
   output logic [FW-1:0] mult_out,
   output logic [FW-1:0] postdiv_out,
   output logic          busy,
   output logic          cfg_err,
   output logic          overrun
);
   localparam int NUM_MAX = LOCK_K * NMAX + MMAX;
   localparam int NUM_W   = $clog2(NUM_MAX + 1);
   localparam int RST_RAW = ceil_div(RST_NS * (REF_KHZ / 1000), 1000)
                            + ((REF_KHZ % 1000) != 0 ? 1 : 0);
   localparam int RST_CYC = (RST_RAW < 1) ? 1 : RST_RAW;

   initial begin
      if (FW < $clog2(NMAX + 1) || FW < $clog2(MMAX + 1) || FW < $clog2(PMAX + 1))
         $error("pll_reprog_seq: FW too narrow for ratio limits");
      if (MMIN < 1 || MMIN > MMAX) $error("pll_reprog_seq: bad multiplier range");
      if (N_DEF < 1 || N_DEF > NMAX) $error("pll_reprog_seq: bad default pre-divider");
      if (M_DEF < MMIN || M_DEF > MMAX) $error("pll_reprog_seq: bad default multiplier");
      if (P_DEF < 1 || P_DEF > PMAX) $error("pll_reprog_seq: bad default post-divider");
      if (LOCK_K < MMAX) $error("pll_reprog_seq: lock constant gives zero-length wait");
      if (RST_CYC >= (1 << NUM_W)) $error("pll_reprog_seq: reset count exceeds counter");
      if (REF_KHZ < 1) $error("pll_reprog_seq: REF_KHZ must be positive");
   end

   seq_state_t       st_q;
   logic [FW-1:0]    n_q, m_q, p_q;
   logic [NUM_W-1:0] cnt_q;
   logic [NUM_W-1:0] lock_q;
   logic             go_q;
   logic             err_q;
   logic             ovr_q;

   logic             busy_w;
   logic             wr_ok;
   logic             accept;
   logic             relock;
   logic             div_done;
   logic [NUM_W-1:0] div_quo;
   logic [NUM_W-1:0] div_num;

   assign busy_w = (st_q == ST_BYPASS) || (st_q == ST_RESET) || (st_q == ST_LOCK);
   assign accept = wr_en && !busy_w;
   assign relock = (wr_prediv != n_q) || (wr_mult != m_q);

   pll_cfg_check #(
      .FW(FW), .NMAX(NMAX), .MMIN(MMIN), .MMAX(MMAX), .PMAX(PMAX),
      .REF_KHZ(REF_KHZ), .FMIN_KHZ(FMIN_KHZ), .FMAX_KHZ(FMAX_KHZ),
      .CHECK_FREQ(CHECK_FREQ)
   ) u_check (
      .n (wr_prediv),
      .m (wr_mult),
      .p (wr_postdiv),
      .ok(wr_ok)
   );

   // Ceiling of LOCK_K*N/M, obtained by biasing the numerator by M-1.
   assign div_num = NUM_W'(LOCK_K) * NUM_W'(n_q) + NUM_W'(m_q) - NUM_W'(1);

   pll_lock_div #(
      .NUM_W(NUM_W),
      .DEN_W(FW)
   ) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .start(go_q),
      .num  (div_num),
      .den  (m_q),
      .done (div_done),
      .quo  (div_quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_BYPASS;
         n_q    <= FW'(N_DEF);
         m_q    <= FW'(M_DEF);
         p_q    <= FW'(P_DEF);
         cnt_q  <= '0;
         lock_q <= '0;
         go_q   <= 1'b1;
         err_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         go_q <= 1'b0;
         unique case (st_q)
            ST_BYPASS: begin
               if (div_done) begin
                  lock_q <= div_quo;
                  cnt_q  <= NUM_W'(RST_CYC - 1);
                  st_q   <= ST_RESET;
               end
            end
            ST_RESET: begin
               if (cnt_q == '0) begin
                  cnt_q <= lock_q;
                  st_q  <= ST_LOCK;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_LOCK: begin
               if (cnt_q == NUM_W'(1)) st_q <= ST_ENABLE;
               else                    cnt_q <= cnt_q - 1'b1;
            end
            ST_ENABLE: st_q <= ST_IDLE;
            default:   st_q <= ST_IDLE;
         endcase

         if (wr_en && busy_w) begin
            ovr_q <= 1'b1;
         end else if (accept) begin
            if (!wr_ok) begin
               err_q <= 1'b1;
            end else begin
               err_q <= 1'b0;
               ovr_q <= 1'b0;
               p_q   <= wr_postdiv;
               if (relock) begin
                  n_q  <= wr_prediv;
                  m_q  <= wr_mult;
                  go_q <= 1'b1;
                  st_q <= ST_BYPASS;
               end
            end
         end
      end
   end

   assign pll_en      = (st_q == ST_IDLE) || (st_q == ST_ENABLE);
   assign pll_rst     = (st_q == ST_RESET);
   assign busy        = busy_w;
   assign prediv_out  = n_q;
   assign mult_out    = m_q;
   assign postdiv_out = p_q;
   assign cfg_err     = err_q;
   assign overrun     = ovr_q;

endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
   parameter int FW       = 6,
   parameter int NMAX     = 32,
   parameter int MMIN     = 4,
   parameter int MMAX     = 32,
   parameter int PMAX     = 32,
   parameter int REF_KHZ  = 25000,
   parameter int FMIN_KHZ = 300000,
   parameter int FMAX_KHZ = 600000,
   parameter int LOCK_K   = 2000,
   parameter int RST_NS   = 1000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [FW-1:0] wr_prediv,
   input logic [FW-1:0] wr_mult,
   input logic [FW-1:0] wr_postdiv,
   input logic          pll_en,
   input logic          pll_rst,
   input logic [FW-1:0] prediv_out,
   input logic [FW-1:0] mult_out,
   input logic [FW-1:0] postdiv_out,
   input logic          busy,
   input logic          cfg_err,
   input logic          overrun
);
   localparam longint RST_EXP_L = (longint'(RST_NS) * REF_KHZ + 999999) / 1000000;
   localparam int     RST_EXP   = (RST_EXP_L < 1) ? 1 : int'(RST_EXP_L);

   function automatic logic legal(input logic [FW-1:0] n, input logic [FW-1:0] m,
                                  input logic [FW-1:0] p);
      longint f, lo, hi;
      f  = longint'(REF_KHZ) * m;
      lo = longint'(FMIN_KHZ) * n;
      hi = longint'(FMAX_KHZ) * n;
      return (n >= 1) && (int'(n) <= NMAX) && (int'(m) >= MMIN) && (int'(m) <= MMAX) &&
             (p >= 1) && (int'(p) <= PMAX) && (f >= lo) && (f <= hi);
   endfunction

   function automatic int lock_of(input logic [FW-1:0] n, input logic [FW-1:0] m);
      return (m == '0) ? 0 : (LOCK_K * int'(n) + int'(m) - 1) / int'(m);
   endfunction

   int rst_run;
   int wait_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_run  <= 0;
         wait_run <= 0;
      end else begin
         rst_run  <= pll_rst ? rst_run + 1 : 0;
         if (pll_rst)                wait_run <= 0;
         else if (!pll_en && busy)   wait_run <= wait_run + 1;
      end
   end

   a_r9_rst_en_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(pll_rst && pll_en));

   a_r9_rst_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      pll_rst |-> busy);

   a_r4_rst_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_rst) |-> (rst_run == RST_EXP));

   a_r5_lock_wait: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_en) |-> (wait_run == lock_of(prediv_out, mult_out)));

   a_r5_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_en) |-> !busy);

   a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> (overrun && $stable(prediv_out) && $stable(mult_out)
                           && $stable(postdiv_out)));

   a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && !legal(wr_prediv, wr_mult, wr_postdiv)) |=>
      (cfg_err && $stable(prediv_out) && $stable(mult_out) && $stable(postdiv_out)));

   a_r6_fast_path: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && legal(wr_prediv, wr_mult, wr_postdiv) &&
       wr_prediv == prediv_out && wr_mult == mult_out) |=>
      (pll_en && !pll_rst && !busy && postdiv_out == $past(wr_postdiv)));

   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && legal(wr_prediv, wr_mult, wr_postdiv)) |=> (!cfg_err && !overrun));

endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
   .FW(FW), .NMAX(NMAX), .MMIN(MMIN), .MMAX(MMAX), .PMAX(PMAX),
   .REF_KHZ(REF_KHZ), .FMIN_KHZ(FMIN_KHZ), .FMAX_KHZ(FMAX_KHZ),
   .LOCK_K(LOCK_K), .RST_NS(RST_NS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
   .wr_prediv(wr_prediv), .wr_mult(wr_mult), .wr_postdiv(wr_postdiv),
   .pll_en(pll_en), .pll_rst(pll_rst),
   .prediv_out(prediv_out), .mult_out(mult_out), .postdiv_out(postdiv_out),
   .busy(busy), .cfg_err(cfg_err), .overrun(overrun)
);

// File: tb/pll_reprog_seq_tb.sv
`timescale 1ns/1ps
module pll_reprog_seq_tb;
   localparam int FW  = 6;
   localparam int REF = 25000;
   localparam int RSTC = 25;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [FW-1:0] wr_prediv = '0, wr_mult = '0, wr_postdiv = '0;
   logic          pll_en, pll_rst, busy, cfg_err, overrun;
   logic [FW-1:0] prediv_out, mult_out, postdiv_out;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int overlap = 0;
   bit finished = 1'b0;
   int cur_n = 1, cur_m = 20, cur_p = 1;

   always #2.5 clk = ~clk;

   pll_reprog_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_prediv(wr_prediv), .wr_mult(wr_mult), .wr_postdiv(wr_postdiv),
      .pll_en(pll_en), .pll_rst(pll_rst),
      .prediv_out(prediv_out), .mult_out(mult_out), .postdiv_out(postdiv_out),
      .busy(busy), .cfg_err(cfg_err), .overrun(overrun)
   );

   function automatic bit in_range(int n, int m, int p);
      return n >= 1 && n <= 32 && m >= 4 && m <= 32 && p >= 1 && p <= 32;
   endfunction

   function automatic bit in_window(int n, int m);
      longint f;
      f = longint'(REF) * m;
      return f >= 64'd300000 * n && f <= 64'd600000 * n;
   endfunction

   function automatic int exp_lock(int n, int m);
      return (2000 * n + m - 1) / m;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         finish_run();
      end
   end

   always @(negedge clk) begin
      if (rst_n && ((pll_rst && pll_en) || (pll_rst && !busy))) overlap++;
   end

   task automatic do_write(int n, int m, int p);
      wr_prediv  = FW'(n);
      wr_mult    = FW'(m);
      wr_postdiv = FW'(p);
      wr_en      = 1'b1;
      @(negedge clk);
      wr_en      = 1'b0;
   endtask

   // Observe one full sequence: reset width, then lock wait, then enable.
   task automatic measure_seq(int n, int m, string tag);
      int w = 0, rc = 0, lc = 0;
      while (!pll_rst && w < 200) begin w++; @(negedge clk); end
      while (pll_rst && rc < 1000) begin rc++; @(negedge clk); end
      chk(rc == RSTC, {tag, " R4 reset width"}, rc, RSTC);
      while (!pll_en && lc < 20000) begin lc++; @(negedge clk); end
      chk(lc == exp_lock(n, m), {tag, " R5 lock wait"}, lc, exp_lock(n, m));
      chk(busy == 1'b0, {tag, " R5 busy low at enable"}, busy, 0);
   endtask

   task automatic apply(int n, int m, int p);
      bit rng, win;
      rng = in_range(n, m, p);
      win = rng && in_window(n, m);
      do_write(n, m, p);
      if (!win) begin
         chk(cfg_err == 1'b1, rng ? "R3 window reject flag" : "R2 range reject flag", cfg_err, 1);
         chk(prediv_out == FW'(cur_n) && mult_out == FW'(cur_m) && postdiv_out == FW'(cur_p),
             rng ? "R3 settings kept" : "R2 settings kept",
             {prediv_out, mult_out, postdiv_out}, {cur_n[5:0], cur_m[5:0], cur_p[5:0]});
      end else begin
         chk(cfg_err == 1'b0 && overrun == 1'b0, "R8 flags cleared", {cfg_err, overrun}, 0);
         cur_p = p;
         if (n != cur_n || m != cur_m) begin
            cur_n = n; cur_m = m;
            chk(busy && !pll_en && prediv_out == FW'(n) && mult_out == FW'(m) && postdiv_out == FW'(p),
                "R4 start of sequence", {busy, pll_en, prediv_out, mult_out}, {2'b10, n[5:0], m[5:0]});
            measure_seq(n, m, "relock");
         end else begin
            chk(postdiv_out == FW'(p), "R6 post-divider updated", postdiv_out, p);
            for (int k = 0; k < 6; k++) begin
               chk(pll_en && !pll_rst && !busy, "R6 no disturbance",
                   {pll_en, pll_rst, busy}, 3'b100);
               @(negedge clk);
            end
         end
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, then the default initialisation sequence
      chk(prediv_out == 1 && mult_out == 20 && postdiv_out == 1, "R1 default settings",
          {prediv_out, mult_out, postdiv_out}, {6'd1, 6'd20, 6'd1});
      chk(busy && !pll_en, "R1 busy and disabled after reset", {busy, pll_en}, 2'b10);
      measure_seq(1, 20, "R1 init");

      // Directed corner cases
      apply(1, 12, 3);     // 300 MHz lower edge, relock
      apply(1, 12, 7);     // post-divider only
      apply(0, 12, 7);     // R2 N too small
      apply(1, 33, 7);     // R2 M too large
      apply(1, 3, 7);      // R2 M too small
      apply(1, 12, 0);     // R2 P zero
      apply(1, 25, 7);     // R3 above window
      apply(1, 11, 7);     // R3 below window
      apply(2, 24, 5);     // 300 MHz with N=2
      apply(1, 24, 32);    // 600 MHz upper edge

      // R7: write while busy is ignored, sticky flag; R8: later clear
      do_write(2, 30, 9);
      cur_n = 2; cur_m = 30; cur_p = 9;
      repeat (4) @(negedge clk);
      do_write(1, 16, 4);
      chk(overrun == 1'b1, "R7 overrun set", overrun, 1);
      measure_seq(2, 30, "R7 sequence unaffected");
      chk(prediv_out == 2 && mult_out == 30 && postdiv_out == 9, "R7 write ignored",
          {prediv_out, mult_out, postdiv_out}, {6'd2, 6'd30, 6'd9});
      chk(overrun == 1'b1, "R7 overrun sticky", overrun, 1);
      apply(2, 30, 11);    // accepted fast-path write clears it (R8)

      // Constrained random mix
      for (int i = 0; i < 30; i++) begin
         int n, m, p, sel;
         sel = int'($urandom % 4);
         if (sel == 0) begin
            n = int'($urandom % 34); m = int'($urandom % 35); p = int'($urandom % 34);
         end else if (sel == 1) begin
            n = cur_n; m = cur_m; p = 1 + int'($urandom % 32);
         end else begin
            n = 1 + int'($urandom % 2);
            m = (n == 1) ? 12 + int'($urandom % 13) : 24 + int'($urandom % 9);
            p = 1 + int'($urandom % 32);
         end
         apply(n, m, p);
      end

      chk(overlap == 0, "R9 reset never with enable or idle", overlap, 0);
      finish_run();
   end
endmodule